// File: doc/BRIEF.md
# Fixed-Point 8x8 Forward DCT Coprocessor

This block is a bus-attached coprocessor that turns one 8x8 block of signed samples into its 64 two-dimensional forward DCT coefficients. A host loads the block by writing 64 samples into a byte-wide load register and starts the transform with a command write. It polls a status byte until the result is ready and then unloads the 64 coefficients through a byte-wide unload register. Each sample and each coefficient is a 16-bit signed value that crosses the bus as two bytes, low byte first.

All arithmetic is integer. A cosine table in Q6 holds round(64·cos(kπ/16)). Every product is shifted right arithmetically by 6. One multiply-accumulate path works through the coefficients one after another, taking one input term per clock, so a transform takes 4096 cycles. The four registers sit at consecutive byte addresses starting at a parameterised base near the top of the 16-bit address space. Reads return data one clock after the read strobe, as a memory-mapped peripheral does.

Top module: `fdct_copro`

## Requirements
- R1: After reset, reading the status register (offset 0) returns 0x00, and a read strobe with no register hit returns 0x00 on the following cycle.
- R2: A byte written to offset 2 while idle loads samples: first the low byte, then the high byte. The k-th completed sample (k = 0..63) is D(x,y) with row x = k/8 and column y = k%8.
- R3: Writing 0x01 to offset 1 while idle starts a transform, and status reads 0x00 while it runs. A write of any other value to offset 1 does nothing.
- R4: When the transform finishes, status reads 0x01. A running transform and the done state never hold together.
- R5: Coefficient (u,v) equals sat((( (S·cu)>>>6 )·cv >>>6) >>>2). Here S = Σx Σy (((D(x,y)·c(x,u))>>>6)·c(y,v))>>>6, c(p,f) = round(64·cos((2p+1)fπ/16)), cu = 45 for u = 0 and 64 otherwise, and cv likewise for v.
- R6: Reads of offset 3 unload coefficients low byte first in the order k = 8u+v. After the 64th coefficient the unload index wraps to coefficient 0.
- R7: Coefficients outside the 16-bit signed range saturate to 32767 or -32768.
- R8: Writing a load byte after a transform has finished sets status back to 0x00.
- R9: The load index wraps after 64 samples, so a 65th sample overwrites sample 0. A start resets the load and unload indices and the byte phase.
- R10: Writes to offset 1 or offset 2 while a transform runs are ignored and do not change the result.
- R11: Read data appears on the cycle after the read strobe. Writes outside the four-register window have no effect, and reads outside it return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Byte address |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe, one cycle per byte |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after rd_i |

## Verification
The transform is exercised with several input blocks. A flat block isolates the DC path and the 45/64 scaling. A linear ramp and a checkerboard drive the odd and the highest-frequency cosine rows, so a wrong sign or a swapped table index shows up. A pseudo-random block with negative values catches truncation that is not arithmetic. Full-scale positive and negative blocks push the DC term past 16 bits to prove the saturation. Load-index wrap, unload wrap and writes during a run each check that the bookkeeping and the ignore rules land on the right sample.

// File: rtl/fdct_pkg.sv
package fdct_pkg;
  localparam int SMP_W = 16;
  localparam int IDX_W = 6;
  localparam int NPTS  = 1 << IDX_W;
  localparam int FRAC  = 6;

  typedef logic signed [SMP_W-1:0] smp_t;

  // Q6 magnitude of cos(k*pi/16) for k = 0..8
  function automatic logic signed [7:0] cos_base(input logic [3:0] k);
    case (k)
      4'd0:    cos_base = 8'sd64;
      4'd1:    cos_base = 8'sd63;
      4'd2:    cos_base = 8'sd59;
      4'd3:    cos_base = 8'sd53;
      4'd4:    cos_base = 8'sd45;
      4'd5:    cos_base = 8'sd36;
      4'd6:    cos_base = 8'sd24;
      4'd7:    cos_base = 8'sd12;
      default: cos_base = 8'sd0;
    endcase
  endfunction

  // Q6 cos((2*pos+1)*freq*pi/16), folded into one quadrant
  function automatic logic signed [7:0] cos_q6(input logic [2:0] pos, input logic [2:0] freq);
    logic [6:0] prod;
    logic [4:0] k;
    logic [4:0] r;
    logic       neg;
    prod = 7'({pos, 1'b1}) * 7'(freq);
    k    = prod[4:0];
    r    = (k > 5'd16) ? 5'd0 - k : k;   // 32-k mod 32
    neg  = (r > 5'd8);
    if (neg) r = 5'd16 - r;
    cos_q6 = neg ? -cos_base(r[3:0]) : cos_base(r[3:0]);
  endfunction
endpackage

// File: rtl/fdct_mac_core.sv
module fdct_mac_core
  import fdct_pkg::*;
#(
  parameter int ACC_W = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             clear_i,
  output logic [IDX_W-1:0] rd_addr_o,
  input  smp_t             sample_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_addr_o,
  output smp_t             coef_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int CNT_W = 2 * IDX_W;
  localparam int P_W   = SMP_W + 9;
  localparam int S_W   = ACC_W + 16;
  localparam logic signed [S_W-1:0] MAX_V = {{(S_W-SMP_W+1){1'b0}}, {(SMP_W-1){1'b1}}};
  localparam logic signed [S_W-1:0] MIN_V = ~MAX_V;

  logic [CNT_W-1:0]        cnt_q;
  logic signed [ACC_W-1:0] acc_q;
  logic                    busy_q, done_q;

  logic [2:0] u, v, x, y;
  assign {u, v, x, y} = cnt_q;

  logic signed [7:0]       cx, cy, cu, cv;
  logic signed [P_W-1:0]   m1, m2;
  logic signed [ACC_W-1:0] acc_nx;
  logic signed [S_W-1:0]   f1, f2, f3;
  logic                    last_term, last_all;

  always_comb begin
    cx = cos_q6(x, u);
    cy = cos_q6(y, v);
    cu = (u == 3'd0) ? 8'sd45 : 8'sd64;
    cv = (v == 3'd0) ? 8'sd45 : 8'sd64;
    m1 = (P_W'(sample_i) * P_W'(cx)) >>> FRAC;
    m2 = (m1 * P_W'(cy)) >>> FRAC;
    acc_nx = acc_q + ACC_W'(m2);
    f1 = (S_W'(acc_nx) * S_W'(cu)) >>> FRAC;
    f2 = (f1 * S_W'(cv)) >>> FRAC;
    f3 = f2 >>> 2;
    if (f3 > MAX_V)      coef_o = smp_t'(MAX_V);
    else if (f3 < MIN_V) coef_o = smp_t'(MIN_V);
    else                 coef_o = smp_t'(f3);
  end

  assign last_term = (cnt_q[IDX_W-1:0] == {IDX_W{1'b1}});
  assign last_all  = (cnt_q == {CNT_W{1'b1}});
  assign rd_addr_o = cnt_q[IDX_W-1:0];
  assign wr_addr_o = cnt_q[CNT_W-1:IDX_W];
  assign wr_en_o   = busy_q && last_term;
  assign busy_o    = busy_q;
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      acc_q <= last_term ? '0 : acc_nx;
      if (last_all) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else if (start_i) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (clear_i) begin
      done_q <= 1'b0;
    end
  end
endmodule

// File: rtl/fdct_host_if.sv
module fdct_host_if
  import fdct_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFFF7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  output logic              start_o,
  output logic              push_o,
  input  logic [IDX_W-1:0]  core_rd_addr_i,
  output smp_t              sample_o,
  input  logic              core_wr_i,
  input  logic [IDX_W-1:0]  core_wr_addr_i,
  input  smp_t              coef_i
);
  localparam logic [1:0] OFF_STAT = 2'd0;
  localparam logic [1:0] OFF_CMD  = 2'd1;
  localparam logic [1:0] OFF_LOAD = 2'd2;
  localparam logic [1:0] OFF_UNLD = 2'd3;

  smp_t in_mem  [NPTS];
  smp_t out_mem [NPTS];

  logic [ADDR_W-1:0] off;
  logic              in_win, wr_load, rd_stat, rd_unld;
  logic [IDX_W-1:0]  ld_idx_q, ul_idx_q;
  logic              ld_hi_q, ul_hi_q;
  logic [7:0]        ld_lo_q;
  smp_t              ul_word;

  assign off     = addr_i - BASE_ADDR;
  assign in_win  = (off < ADDR_W'(4));
  assign start_o = wr_i && in_win && (off[1:0] == OFF_CMD) && (wdata_i == 8'h01) && !busy_i;
  assign wr_load = wr_i && in_win && (off[1:0] == OFF_LOAD) && !busy_i;
  assign push_o  = wr_load;
  assign rd_stat = rd_i && in_win && (off[1:0] == OFF_STAT);
  assign rd_unld = rd_i && in_win && (off[1:0] == OFF_UNLD);
  assign sample_o = in_mem[core_rd_addr_i];
  assign ul_word  = out_mem[ul_idx_q];

  always_ff @(posedge clk_i) begin
    if (wr_load && ld_hi_q) in_mem[ld_idx_q] <= smp_t'({wdata_i, ld_lo_q});
    if (core_wr_i)          out_mem[core_wr_addr_i] <= coef_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_idx_q <= '0;
      ld_hi_q  <= 1'b0;
      ld_lo_q  <= '0;
      ul_idx_q <= '0;
      ul_hi_q  <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rdata_o <= '0;
      if (rd_stat) rdata_o <= {7'd0, done_i};
      if (rd_unld) begin
        rdata_o <= ul_hi_q ? ul_word[15:8] : ul_word[7:0];
        ul_hi_q <= ~ul_hi_q;
        if (ul_hi_q) ul_idx_q <= ul_idx_q + 1'b1;
      end
      if (wr_load) begin
        ld_hi_q <= ~ld_hi_q;
        if (!ld_hi_q) ld_lo_q <= wdata_i;
        else          ld_idx_q <= ld_idx_q + 1'b1;
      end
      if (start_o) begin
        ld_idx_q <= '0;
        ld_hi_q  <= 1'b0;
        ul_idx_q <= '0;
        ul_hi_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fdct_copro.sv
module fdct_copro
  import fdct_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFFF7,
  parameter int                ACC_W     = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  logic             busy, done, start, push, core_wr;
  logic [IDX_W-1:0] core_rd_addr, core_wr_addr;
  smp_t             sample, coef;

  fdct_host_if #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_if (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .addr_i         (addr_i),
    .wr_i           (wr_i),
    .rd_i           (rd_i),
    .wdata_i        (wdata_i),
    .rdata_o        (rdata_o),
    .busy_i         (busy),
    .done_i         (done),
    .start_o        (start),
    .push_o         (push),
    .core_rd_addr_i (core_rd_addr),
    .sample_o       (sample),
    .core_wr_i      (core_wr),
    .core_wr_addr_i (core_wr_addr),
    .coef_i         (coef)
  );

  fdct_mac_core #(.ACC_W(ACC_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .clear_i   (push),
    .rd_addr_o (core_rd_addr),
    .sample_i  (sample),
    .wr_en_o   (core_wr),
    .wr_addr_o (core_wr_addr),
    .coef_o    (coef),
    .busy_o    (busy),
    .done_o    (done)
  );
endmodule

// File: rtl/fdct_copro_chk.sv
module fdct_copro_chk #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFFF7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_o,
  input logic              busy_i,
  input logic              done_i
);
  logic [ADDR_W-1:0] a_cmd, a_load;
  assign a_cmd  = BASE_ADDR + ADDR_W'(1);
  assign a_load = BASE_ADDR + ADDR_W'(2);

  // R4
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_i && done_i));

  // R4
  finish_sets_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> done_i);

  // R3
  start_runs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == a_cmd && wdata_i == 8'h01 && !busy_i) |=> busy_i);

  // R8
  load_clears_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == a_load && !busy_i) |=> !done_i);

  // R11
  status_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == BASE_ADDR) |=> rdata_o == {7'd0, $past(done_i)});

  // R11
  idle_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> rdata_o == 8'h00);
endmodule

bind fdct_copro fdct_copro_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wr_i    (wr_i),
  .rd_i    (rd_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .busy_i  (busy),
  .done_i  (done)
);

// File: tb/fdct_copro_test.sv
module fdct_copro_test;
  localparam logic [15:0] BASE = 16'hFFF7;
  localparam logic [15:0] A_STAT = BASE;
  localparam logic [15:0] A_CMD  = BASE + 16'd1;
  localparam logic [15:0] A_LOAD = BASE + 16'd2;
  localparam logic [15:0] A_UNLD = BASE + 16'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;

  int n_chk = 0;
  int n_bad = 0;
  int blk [64];
  int expv [64];

  always #10 clk = ~clk;

  fdct_copro uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic check(input string req, input string what, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  function automatic int cq(input int p, input int f);
    real r;
    r = $cos(real'((2 * p + 1) * f) * 3.14159265358979 / 16.0) * 64.0;
    return int'(r);
  endfunction

  // R5 R7 reference
  task automatic model();
    for (int u = 0; u < 8; u++)
      for (int v = 0; v < 8; v++) begin
        longint s = 0, f;
        for (int x = 0; x < 8; x++)
          for (int y = 0; y < 8; y++) begin
            longint t;
            t = (longint'(blk[8*x+y]) * cq(x, u)) >>> 6;
            t = (t * cq(y, v)) >>> 6;
            s += t;
          end
        f = (s * ((u == 0) ? 45 : 64)) >>> 6;
        f = (f * ((v == 0) ? 45 : 64)) >>> 6;
        f = f >>> 2;
        if (f > 32767) f = 32767;
        if (f < -32768) f = -32768;
        expv[8*u+v] = int'(f);
      end
  endtask

  task automatic load_word(input int w);
    logic [15:0] b = 16'(w);
    bus_wr(A_LOAD, b[7:0]);
    bus_wr(A_LOAD, b[15:8]);
  endtask

  task automatic load_block();
    for (int k = 0; k < 64; k++) load_word(blk[k]);
  endtask

  task automatic wait_done(input string req);
    logic [7:0] s = 8'h00;
    int n = 0;
    while (s != 8'h01 && n < 3000) begin bus_rd(A_STAT, s); n++; end
    check(req, "status reaches done", int'(s), 1);
  endtask

  task automatic unload_word(output int w);
    logic [7:0] lo, hi;
    bus_rd(A_UNLD, lo);
    bus_rd(A_UNLD, hi);
    w = int'($signed({hi, lo}));
  endtask

  task automatic unload_check(input string req);
    int w;
    for (int k = 0; k < 64; k++) begin
      unload_word(w);
      check(req, $sformatf("coef %0d", k), w, expv[k]);
    end
  endtask

  task automatic run_block(input string req);
    model();
    load_block();
    bus_wr(A_CMD, 8'h01);
    wait_done("R4");
    unload_check(req);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    bus_rd(A_STAT, d);
    check("R1", "status after reset", int'(d), 0);
    bus_rd(16'h1234, d);
    check("R11", "read outside window", int'(d), 0);
  endtask

  task automatic t_flat();
    for (int k = 0; k < 64; k++) blk[k] = 100;
    run_block("R2 R5 R6 flat");
  endtask

  task automatic t_ramp();
    for (int k = 0; k < 64; k++) blk[k] = k * 3 - 90;
    run_block("R5 ramp");
  endtask

  task automatic t_checker();
    for (int k = 0; k < 64; k++) blk[k] = (((k >> 3) + k) & 1) ? -120 : 120;
    run_block("R5 checker");
  endtask

  task automatic t_random();
    logic [15:0] lf = 16'hACE1;
    for (int k = 0; k < 64; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      blk[k] = int'(lf % 16'd4001) - 2000;
    end
    run_block("R5 random");
  endtask

  task automatic t_sat();
    for (int k = 0; k < 64; k++) blk[k] = 32767;
    run_block("R7 positive");
    check("R7", "dc clipped high", expv[0], 32767);
    for (int k = 0; k < 64; k++) blk[k] = -32768;
    run_block("R7 negative");
    check("R7", "dc clipped low", expv[0], -32768);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] d;
    for (int k = 0; k < 64; k++) blk[k] = (k % 7) * 20 - 50;
    model();
    load_block();
    bus_wr(A_CMD, 8'h01);
    bus_rd(A_STAT, d);
    check("R3", "status while running", int'(d), 0);
    for (int k = 0; k < 10; k++) bus_wr(A_LOAD, 8'h7F);  // R10
    bus_wr(A_CMD, 8'h01);
    wait_done("R4");
    unload_check("R10 writes while busy");
    bus_wr(A_CMD, 8'h02);
    bus_rd(A_STAT, d);
    check("R3", "non-one command ignored", int'(d), 1);
    bus_wr(BASE - 16'd1, 8'h01);
    bus_wr(BASE + 16'd4, 8'h01);
    bus_rd(A_STAT, d);
    check("R11", "write outside window ignored", int'(d), 1);
  endtask

  task automatic t_clear();
    logic [7:0] d;
    bus_wr(A_LOAD, 8'h00);
    bus_rd(A_STAT, d);
    check("R8", "load byte clears done", int'(d), 0);
  endtask

  task automatic t_wrap();
    int w;
    for (int k = 0; k < 64; k++) blk[k] = 500 - k * 11;
    bus_wr(A_CMD, 8'h01);
    wait_done("R4");
    load_block();
    load_word(-777);
    blk[0] = -777;
    model();
    bus_wr(A_CMD, 8'h01);
    wait_done("R4");
    unload_check("R9 load wrap");
    unload_word(w);
    check("R6", "unload index wraps", w, expv[0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R4 actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_flat();
    t_ramp();
    t_checker();
    t_random();
    t_sat();
    t_busy_ignore();
    t_clear();
    t_wrap();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule